// File: doc/BRIEF.md
# Debug-Aware Peripheral Run Control

This block is a small set of memory-mapped control registers in a microcontroller. It decides which peripheral clock enables keep running and which ones freeze while the CPU core is halted for debugging. Software sets a run bit for the shared system-clock prescaler. Software also sets one debug-run policy bit for the system-clock peripheral group and another for the group clocked from other internal sources. The block combines these bits with a registered copy of the core's halt indication and drives three enables.

The same register space holds a memory configuration register. That register carries a 3-bit internal-RAM size code and a debug vector base-address select. The block decodes both fields. The size code becomes a size in kilobytes. An unsupported size code makes the decoded size fall back to 8 KB and raises a flag that stays set until reset. The base select becomes a 24-bit base address.

The register bus is synchronous. A write takes effect on the clock edge where the write enable is high. Read data is a combinational function of the address.

Top module: `dbg_run_ctrl`

## Requirements
- R1: After reset:
  - the clock control register (0x5320) reads 0x0000, the other-clock register (0x5322) reads 0x0000 and the memory configuration register (0x5326) reads 0x0011;
  - `presc_run_o` is 0, `sys_en_o` is 0 and `aux_en_o` is 1;
  - `ram_kb_o` is 8, `ram_cfg_bad_o` is 0 and `dbg_base_o` is 0xFFFC00.
- R2: In register 0x5320, bit 0 is the prescaler run bit and bit 1 is the system-clock debug-run bit; bits 15 to 2 read as 0. `presc_run_o` follows bit 0 from the clock after the write.
- R3: `sys_en_o` equals the prescaler run bit AND (NOT halted OR the system-clock debug-run bit). "Halted" here means the value of `core_halted_i` registered at the previous clock edge.
- R4: `core_halted_i` affects no output in the cycle where it changes. The enables change only after the next clock edge.
- R5: Register 0x5322 holds the other-clock debug-run bit in bit 0, and its bits 15 to 1 read as 0. `aux_en_o` equals NOT halted OR this bit, independent of the prescaler run bit.
- R6: Bits 2 to 0 of 0x5326 hold the RAM size code. Code 3 decodes to `ram_kb_o` = 2, code 2 to 4, and code 1 to 8.
- R7: A reserved size code (0, 4, 5, 6 or 7) is stored and reads back as written. For such a code, `ram_kb_o` shows 8 and `ram_cfg_bad_o` becomes 1. `ram_cfg_bad_o` then stays 1 after a legal code is written, until reset.
- R8: Bit 8 of 0x5326 selects the debug base address: 1 gives `dbg_base_o` = 0x000000 and 0 gives 0xFFFC00. The output changes in the cycle after the write.
- R9: In 0x5326, bits 15 to 9, bit 7 and bit 3 always read 0, and bits 6 to 4 always read 0b001. Writing any value to these bits has no effect.
- R10: A write to any other address changes no register. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| core_halted_i | input | 1 | High while the core is halted in debug mode |
| presc_run_o | output | 1 | Run enable for the shared peripheral prescaler |
| sys_en_o | output | 1 | Gated enable for the system-clock peripheral group |
| aux_en_o | output | 1 | Gated enable for peripherals on other internal clocks |
| ram_kb_o | output | 4 | Decoded internal-RAM size in kilobytes |
| ram_cfg_bad_o | output | 1 | Sticky flag for a reserved RAM size code |
| dbg_base_o | output | 24 | Decoded debug vector base address |

## Verification
Several properties are checked on every cycle:
- each enable follows the halt input as it was sampled one edge earlier;
- `sys_en_o` never rises without the prescaler run bit;
- the size output only ever holds one of the three legal sizes;
- the illegal-configuration flag never falls outside reset;
- writes to unmapped addresses leave the stored state unchanged.

Other behaviour can only be shown by the directed scenarios. These cover the exact register read patterns, including the fixed reserved fields. They also cover the one-cycle delay between a halt edge and the enable change, seen from outside. Finally, they cover the mapping of each size code and base select to its decoded value, and the flag staying high after a legal code is written.

// File: rtl/dbgrun_pkg.sv
package dbgrun_pkg;

   // Stored control state of the block
   typedef struct packed {
      logic       presc_run;    // prescaler run bit
      logic       sys_dbg_run;  // system-clock group runs while halted
      logic       aux_dbg_run;  // other-clock group runs while halted
      logic       base_sel;     // debug base address select
      logic [2:0] ram_code;     // RAM size code
   } ctl_t;

   localparam logic [2:0] RAM_CODE_2K = 3'd3;
   localparam logic [2:0] RAM_CODE_4K = 3'd2;
   localparam logic [2:0] RAM_CODE_8K = 3'd1;

   localparam logic [2:0] RAM_RSVD_FILL = 3'b001;

   function automatic logic ram_code_legal(input logic [2:0] code);
      return (code == RAM_CODE_2K) || (code == RAM_CODE_4K) || (code == RAM_CODE_8K);
   endfunction

endpackage

// File: rtl/dbgrun_regs.sv
module dbgrun_regs
   import dbgrun_pkg::*;
#(
   parameter int          ADDR_W  = 16,
   parameter int          DATA_W  = 16,
   parameter logic [15:0] CLK_OFS = 16'h5320,
   parameter logic [15:0] AUX_OFS = 16'h5322,
   parameter logic [15:0] MEM_OFS = 16'h5326
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output ctl_t              ctl
);

   localparam int BASE_BIT = 8;
   localparam int FILL_LSB = 4;

   if (DATA_W < 16) begin : g_chk_data
      $error("dbgrun_regs: DATA_W must be at least 16");
   end
   if (ADDR_W < 16) begin : g_chk_addr
      $error("dbgrun_regs: ADDR_W must be at least 16");
   end

   localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(CLK_OFS);
   localparam logic [ADDR_W-1:0] A_AUX = ADDR_W'(AUX_OFS);
   localparam logic [ADDR_W-1:0] A_MEM = ADDR_W'(MEM_OFS);

   ctl_t ctl_q;
   logic hit_clk, hit_aux, hit_mem, hit_any;

   assign hit_clk = (addr == A_CLK);
   assign hit_aux = (addr == A_AUX);
   assign hit_mem = (addr == A_MEM);
   assign hit_any = hit_clk | hit_aux | hit_mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q.presc_run   <= 1'b0;
         ctl_q.sys_dbg_run <= 1'b0;
         ctl_q.aux_dbg_run <= 1'b0;
         ctl_q.base_sel    <= 1'b0;
         ctl_q.ram_code    <= RAM_CODE_8K;
      end else if (we) begin
         if (hit_clk) begin
            ctl_q.presc_run   <= wdata[0];
            ctl_q.sys_dbg_run <= wdata[1];
         end
         if (hit_aux) begin
            ctl_q.aux_dbg_run <= wdata[0];
         end
         if (hit_mem) begin
            ctl_q.base_sel <= wdata[BASE_BIT];
            ctl_q.ram_code <= wdata[2:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_clk) begin
         rdata[0] = ctl_q.presc_run;
         rdata[1] = ctl_q.sys_dbg_run;
      end else if (hit_aux) begin
         rdata[0] = ctl_q.aux_dbg_run;
      end else if (hit_mem) begin
         rdata[2:0]                  = ctl_q.ram_code;
         rdata[FILL_LSB+2:FILL_LSB]  = RAM_RSVD_FILL;
         rdata[BASE_BIT]             = ctl_q.base_sel;
      end
   end

   assign ctl = ctl_q;

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   // R10
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !hit_any) |=> $stable(ctl_q))
      else $error("write to unmapped address changed state");

endmodule

// File: rtl/dbgrun_gate.sv
module dbgrun_gate #(
   parameter int DBG_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halted_i,
   input  logic presc_run_i,
   input  logic sys_dbg_run_i,
   input  logic aux_dbg_run_i,
   output logic sys_en_o,
   output logic aux_en_o
);

   localparam int LAST = DBG_STAGES - 1;

   if (DBG_STAGES < 1) begin : g_chk_stages
      $error("dbgrun_gate: DBG_STAGES must be at least 1");
   end

   logic [LAST:0] halt_q;
   logic          last_in;

   if (DBG_STAGES == 1) begin : g_single
      assign last_in = halted_i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) halt_q <= '0;
         else        halt_q <= halted_i;
      end
   end else begin : g_chain
      assign last_in = halt_q[LAST-1];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) halt_q <= '0;
         else        halt_q <= {halt_q[LAST-1:0], halted_i};
      end
   end

   logic halted_q;
   assign halted_q = halt_q[LAST];

   assign sys_en_o = presc_run_i & (~halted_q | sys_dbg_run_i);
   assign aux_en_o = ~halted_q | aux_dbg_run_i;

   // warm-up marker: one edge has passed since reset release
   logic warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warm_q <= 1'b0;
      else        warm_q <= 1'b1;
   end

   // R3
   sys_needs_presc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_en_o |-> presc_run_i)
      else $error("system enable without prescaler run");

   // R4
   sys_follows_past_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q && !$past(last_in) && presc_run_i) |-> sys_en_o)
      else $error("system enable dropped without prior halt");

   // R5
   aux_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q && $past(last_in) && !aux_dbg_run_i) |-> !aux_en_o)
      else $error("other-clock enable not frozen while halted");

   // R5
   aux_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q && !$past(last_in)) |-> aux_en_o)
      else $error("other-clock enable low while running");

endmodule

// File: rtl/dbgrun_memcfg.sv
module dbgrun_memcfg
   import dbgrun_pkg::*;
#(
   parameter int          KB_W      = 4,
   parameter int          BASE_W    = 24,
   parameter logic [23:0] BASE_HIGH = 24'hFFFC00,
   parameter logic [23:0] BASE_LOW  = 24'h000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        ram_code_i,
   input  logic              base_sel_i,
   output logic [KB_W-1:0]   ram_kb_o,
   output logic              cfg_bad_o,
   output logic [BASE_W-1:0] dbg_base_o
);

   localparam logic [KB_W-1:0] KB_2 = KB_W'(2);
   localparam logic [KB_W-1:0] KB_4 = KB_W'(4);
   localparam logic [KB_W-1:0] KB_8 = KB_W'(8);

   if (KB_W < 4) begin : g_chk_kb
      $error("dbgrun_memcfg: KB_W too narrow for 8");
   end
   if (BASE_W < 1 || BASE_W > 24) begin : g_chk_base
      $error("dbgrun_memcfg: BASE_W must be 1..24");
   end

   logic code_ok;
   assign code_ok = ram_code_legal(ram_code_i);

   always_comb begin
      unique case (ram_code_i)
         RAM_CODE_2K: ram_kb_o = KB_2;
         RAM_CODE_4K: ram_kb_o = KB_4;
         default:     ram_kb_o = KB_8;
      endcase
   end

   logic bad_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bad_q <= 1'b0;
      else        bad_q <= bad_q | ~code_ok;
   end
   assign cfg_bad_o = bad_q | ~code_ok;

   if (BASE_W == 24) begin : g_full_base
      assign dbg_base_o = base_sel_i ? BASE_LOW : BASE_HIGH;
   end else begin : g_trim_base
      assign dbg_base_o = base_sel_i ? BASE_LOW[BASE_W-1:0] : BASE_HIGH[BASE_W-1:0];
   end

   // R6
   size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(ram_kb_o) == 1) && (ram_kb_o <= KB_8) && (ram_kb_o >= KB_2))
      else $error("decoded RAM size not a legal size");

   // R7
   bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_bad_o) |-> cfg_bad_o)
      else $error("illegal configuration flag cleared");

   // R7
   bad_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !code_ok |-> (cfg_bad_o && ram_kb_o == KB_8))
      else $error("reserved code did not fall back");

endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
   import dbgrun_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int KB_W       = 4,
   parameter int BASE_W     = 24,
   parameter int DBG_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              core_halted_i,
   output logic              presc_run_o,
   output logic              sys_en_o,
   output logic              aux_en_o,
   output logic [KB_W-1:0]   ram_kb_o,
   output logic              ram_cfg_bad_o,
   output logic [BASE_W-1:0] dbg_base_o
);

   ctl_t ctl;

   dbgrun_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .we    (bus_we),
      .wdata (bus_wdata),
      .rdata (bus_rdata),
      .ctl   (ctl)
   );

   dbgrun_gate #(
      .DBG_STAGES (DBG_STAGES)
   ) u_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .halted_i      (core_halted_i),
      .presc_run_i   (ctl.presc_run),
      .sys_dbg_run_i (ctl.sys_dbg_run),
      .aux_dbg_run_i (ctl.aux_dbg_run),
      .sys_en_o      (sys_en_o),
      .aux_en_o      (aux_en_o)
   );

   dbgrun_memcfg #(
      .KB_W   (KB_W),
      .BASE_W (BASE_W)
   ) u_memcfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .ram_code_i (ctl.ram_code),
      .base_sel_i (ctl.base_sel),
      .ram_kb_o   (ram_kb_o),
      .cfg_bad_o  (ram_cfg_bad_o),
      .dbg_base_o (dbg_base_o)
   );

   assign presc_run_o = ctl.presc_run;

   // R2
   presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == ADDR_W'(16'h5320)) |=> $stable(presc_run_o))
      else $error("prescaler run changed without a write");

endmodule

// File: tb/dbg_run_ctrl_test.sv
module dbg_run_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        core_halted_i = 1'b0;
   logic        presc_run_o, sys_en_o, aux_en_o, ram_cfg_bad_o;
   logic [3:0]  ram_kb_o;
   logic [23:0] dbg_base_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [15:0] A_CLK = 16'h5320;
   localparam logic [15:0] A_AUX = 16'h5322;
   localparam logic [15:0] A_MEM = 16'h5326;

   always #2 clk = ~clk;

   dbg_run_ctrl uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_addr      (bus_addr),
      .bus_we        (bus_we),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .core_halted_i (core_halted_i),
      .presc_run_o   (presc_run_o),
      .sys_en_o      (sys_en_o),
      .aux_en_o      (aux_en_o),
      .ram_kb_o      (ram_kb_o),
      .ram_cfg_bad_o (ram_cfg_bad_o),
      .dbg_base_o    (dbg_base_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [15:0] exp);
      bus_addr = a;
      #1;
      check(req, $sformatf("read 0x%0h", a), 32'(bus_rdata), 32'(exp));
   endtask

   task automatic t_reset;
      rd_chk("R1", A_CLK, 16'h0000);
      rd_chk("R1", A_AUX, 16'h0000);
      rd_chk("R1", A_MEM, 16'h0011);
      check("R1", "presc_run", 32'(presc_run_o), 32'd0);
      check("R1", "sys_en", 32'(sys_en_o), 32'd0);
      check("R1", "aux_en", 32'(aux_en_o), 32'd1);
      check("R1", "ram_kb", 32'(ram_kb_o), 32'd8);
      check("R1", "cfg_bad", 32'(ram_cfg_bad_o), 32'd0);
      check("R1", "dbg_base", 32'(dbg_base_o), 32'hFFFC00);
   endtask

   task automatic t_prescaler;
      wr(A_CLK, 16'hFFFD);  // bit0=1 bit1=0
      check("R2", "presc_run after write", 32'(presc_run_o), 32'd1);
      check("R3", "sys_en running", 32'(sys_en_o), 32'd1);
      rd_chk("R2", A_CLK, 16'h0001);
      wr(A_CLK, 16'h0002);
      check("R2", "presc_run stopped", 32'(presc_run_o), 32'd0);
      check("R3", "sys_en without prescaler", 32'(sys_en_o), 32'd0);
      rd_chk("R2", A_CLK, 16'h0002);
   endtask

   task automatic t_sys_debug;
      wr(A_CLK, 16'h0001);  // run, freeze on halt
      core_halted_i = 1'b1;
      #1;
      check("R4", "sys_en same cycle as halt", 32'(sys_en_o), 32'd1);
      @(negedge clk);
      check("R3", "sys_en frozen while halted", 32'(sys_en_o), 32'd0);
      check("R2", "presc_run unaffected by halt", 32'(presc_run_o), 32'd1);
      wr(A_CLK, 16'h0003);  // keep running in halt
      check("R3", "sys_en runs while halted", 32'(sys_en_o), 32'd1);
      wr(A_CLK, 16'h0001);
      core_halted_i = 1'b0;
      #1;
      check("R4", "sys_en still frozen same cycle", 32'(sys_en_o), 32'd0);
      @(negedge clk);
      check("R3", "sys_en resumes", 32'(sys_en_o), 32'd1);
   endtask

   task automatic t_aux_debug;
      wr(A_CLK, 16'h0000);
      check("R5", "aux_en without prescaler", 32'(aux_en_o), 32'd1);
      core_halted_i = 1'b1;
      #1;
      check("R4", "aux_en same cycle as halt", 32'(aux_en_o), 32'd1);
      @(negedge clk);
      check("R5", "aux_en frozen", 32'(aux_en_o), 32'd0);
      wr(A_AUX, 16'hFFFF);
      rd_chk("R5", A_AUX, 16'h0001);
      check("R5", "aux_en runs in halt", 32'(aux_en_o), 32'd1);
      check("R3", "sys_en stays off", 32'(sys_en_o), 32'd0);
      wr(A_AUX, 16'h0000);
      check("R5", "aux_en frozen again", 32'(aux_en_o), 32'd0);
      core_halted_i = 1'b0;
      @(negedge clk);
      check("R5", "aux_en after resume", 32'(aux_en_o), 32'd1);
   endtask

   task automatic t_ram_size;
      wr(A_MEM, 16'h0003);
      check("R6", "code 3", 32'(ram_kb_o), 32'd2);
      wr(A_MEM, 16'h0002);
      check("R6", "code 2", 32'(ram_kb_o), 32'd4);
      wr(A_MEM, 16'h0001);
      check("R6", "code 1", 32'(ram_kb_o), 32'd8);
      check("R6", "no bad flag for legal codes", 32'(ram_cfg_bad_o), 32'd0);
   endtask

   task automatic t_base;
      wr(A_MEM, 16'h0101);
      check("R8", "base select 1", 32'(dbg_base_o), 32'h000000);
      rd_chk("R8", A_MEM, 16'h0111);
      wr(A_MEM, 16'h0001);
      check("R8", "base select 0", 32'(dbg_base_o), 32'hFFFC00);
   endtask

   task automatic t_reserved;
      wr(A_MEM, 16'hFEFA);  // size 2, base 0, reserved bits toggled
      rd_chk("R9", A_MEM, 16'h0012);
      check("R9", "size from masked write", 32'(ram_kb_o), 32'd4);
      check("R9", "base from masked write", 32'(dbg_base_o), 32'hFFFC00);
   endtask

   task automatic t_bad_code;
      wr(A_MEM, 16'hFFFF);  // size 7 reserved, base 1
      rd_chk("R7", A_MEM, 16'h0117);
      check("R7", "fallback size", 32'(ram_kb_o), 32'd8);
      check("R7", "bad flag set", 32'(ram_cfg_bad_o), 32'd1);
      wr(A_MEM, 16'h0003);
      check("R7", "legal size after bad", 32'(ram_kb_o), 32'd2);
      check("R7", "bad flag sticky", 32'(ram_cfg_bad_o), 32'd1);
      wr(A_MEM, 16'h0000);
      rd_chk("R7", A_MEM, 16'h0010);
      check("R7", "code 0 fallback", 32'(ram_kb_o), 32'd8);
   endtask

   task automatic t_unmapped;
      wr(A_CLK, 16'h0001);
      wr(A_AUX, 16'h0000);
      wr(A_MEM, 16'h0002);
      wr(16'h5324, 16'hFFFF);
      wr(16'h5321, 16'hFFFF);
      wr(16'h0000, 16'hFFFF);
      rd_chk("R10", 16'h5324, 16'h0000);
      rd_chk("R10", A_CLK, 16'h0001);
      rd_chk("R10", A_AUX, 16'h0000);
      rd_chk("R10", A_MEM, 16'h0012);
   endtask

   task automatic t_rereset;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "bad flag cleared by reset", 32'(ram_cfg_bad_o), 32'd0);
      rd_chk("R1", A_MEM, 16'h0011);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prescaler();
      t_sys_debug();
      t_aux_debug();
      t_ram_size();
      t_base();
      t_reserved();
      t_bad_code();
      t_unmapped();
      t_rereset();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule